// File: doc/BRIEF.md
# Two-Stage Nested Priority Event Controller

The controller decides which event the core services next. It has sixteen priority levels. Four levels are fixed core classes: emulation, core reset, nonmaskable interrupt and exception. The general-purpose levels run from GP_BASE (7 by default) up to 15. Levels 4 to 6 are unused. Lower level numbers win. Requests from peripherals first pass through a system stage. This stage has one enable bit and one target-level field for each source, and forwards each source onto its chosen general-purpose level. Software can also raise a general-purpose level directly.

A request is latched as pending. It is taken only when its level beats every routine that is already active. This is how nesting works: a more urgent event can interrupt a running routine, and a less urgent one waits. On a take, the controller pulses `take` and reports the level. It marks the level as active and stores the current program address in a return register owned by that level. A return-from-event pulse retires the most urgent active routine.

Top module: `evc_top`

## Requirements
- R1: After synchronous reset, `take` is 0, `active` is all zeros, and no level is pending.
- R2: Level encoding: 0 is emulation (`emu_req`), 1 is core reset (`rst_evt_req`), 2 is NMI and 3 is exception (`exc_req`). GP_BASE to 15 are general-purpose. When `take` is 1, `take_lvl` gives the level taken and `active[take_lvl]` is 1.
- R3: When several levels are pending, the lowest-numbered one is taken first.
- R4: A pending level is taken only if its number is lower than every set bit of `active`. Until then it stays pending. Routines nest: a take adds its bit to `active` and leaves the other bits in place.
- R5: A `rfe` pulse clears the lowest-numbered set bit of `active`. A waiting level that then qualifies is taken on the next edge.
- R6: A core-stage request sampled at rising edge N gives `take` = 1 after edge N+1. A peripheral request gives `take` = 1 after edge N+2.
- R7: Level 2 (NMI) becomes pending when either `nmi_pin` or `wdog_expire` is 1.
- R8: A write with `cfg_we` stores `cfg_en` and `cfg_lvl` for source `cfg_src`. An `irq` line raises its assigned level only if its enable bit is 1 and the assigned level is at least GP_BASE. Otherwise it has no effect. After reset, all enables are 0.
- R9: A `swi_req` pulse makes level `swi_lvl` pending if `swi_lvl` is at least GP_BASE. Otherwise it is ignored.
- R10: At each take, `pc_in` is written into the return register of the level taken. `ret_addr` returns the register selected by `ret_sel` one edge after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| emu_req | input | 1 | Emulation request (level 0) |
| rst_evt_req | input | 1 | Core reset event request (level 1) |
| nmi_pin | input | 1 | External NMI request |
| wdog_expire | input | 1 | Watchdog timeout, also raises NMI |
| exc_req | input | 1 | Synchronous exception request (level 3) |
| swi_req | input | 1 | Software raise strobe |
| swi_lvl | input | 4 | Level to raise by software |
| irq | input | 2**SRC_W | Peripheral request lines |
| cfg_we | input | 1 | Write one source's route entry |
| cfg_src | input | SRC_W | Source being configured |
| cfg_en | input | 1 | Enable bit for the source |
| cfg_lvl | input | 4 | Target level for the source |
| pc_in | input | AW | Address to save on a take |
| rfe | input | 1 | Return-from-event pulse |
| ret_sel | input | 4 | Return register to read |
| take | output | 1 | Take-event strobe |
| take_lvl | output | 4 | Level taken |
| active | output | 16 | Levels whose routines are active |
| ret_addr | output | AW | Selected return register |

## Verification
Several properties are checked on every cycle:
- Every take is strictly more urgent than all routines active before it.
- Every take is the lowest-numbered pending level.
- A pending bit disappears only through a take.
- A return with no take at the same edge removes exactly one active bit.
- The system stage never drives a fixed core level.

Some behaviours need the bench's scenarios and its reference model:
- the exact take latency of each path;
- that both NMI causes work;
- that disabled or misrouted sources and low-level software raises are ignored;
- the contents of the return registers.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NLVL = 16;
  localparam int LW   = $clog2(NLVL);

  typedef logic [LW-1:0]   lvl_t;
  typedef logic [NLVL-1:0] lvec_t;

  localparam lvl_t LV_EMU = lvl_t'(0);
  localparam lvl_t LV_RST = lvl_t'(1);
  localparam lvl_t LV_NMI = lvl_t'(2);
  localparam lvl_t LV_EXC = lvl_t'(3);

  typedef struct packed {
    logic en;
    lvl_t lvl;
  } route_t;

  // lowest set bit isolated
  function automatic lvec_t low_bit(lvec_t v);
    return v & (~v + lvec_t'(1));
  endfunction

  // index of lowest set bit, 0 when empty
  function automatic lvl_t low_idx(lvec_t v);
    lvl_t r = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (v[i]) r = lvl_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/evc_sys_stage.sv
module evc_sys_stage
  import evc_pkg::*;
#(
  parameter int SRC_W   = 3,
  parameter int GP_BASE = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [(1<<SRC_W)-1:0] irq,
  input  logic                 cfg_we,
  input  logic [SRC_W-1:0]     cfg_src,
  input  logic                 cfg_en,
  input  lvl_t                 cfg_lvl,
  output lvec_t                gp_req
);
  localparam int   NSRC = 1 << SRC_W;
  localparam lvl_t GPB  = lvl_t'(GP_BASE);

  route_t tbl [NSRC];
  lvec_t  routed;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSRC; s++) tbl[s] <= '{en: 1'b0, lvl: lvl_t'(NLVL - 1)};
    end else if (cfg_we) begin
      tbl[cfg_src] <= '{en: cfg_en, lvl: cfg_lvl};
    end
  end

  always_comb begin
    routed = '0;
    for (int s = 0; s < NSRC; s++)
      if (irq[s] && tbl[s].en && (tbl[s].lvl >= GPB))
        routed[tbl[s].lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gp_req <= '0;
    else     gp_req <= routed;
  end
endmodule

// File: rtl/evc_core_prio.sv
module evc_core_prio
  import evc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  lvec_t set_vec,
  input  logic  rfe,
  output logic  sel_valid,
  output lvl_t  sel_lvl,
  output logic  take,
  output lvl_t  take_lvl,
  output lvec_t active,
  output lvec_t pend
);
  lvl_t  act_top;
  lvec_t sel_hot;
  lvec_t act_keep;

  always_comb begin
    sel_lvl   = low_idx(pend);
    act_top   = low_idx(active);
    sel_valid = (pend != '0) && ((active == '0) || (sel_lvl < act_top));
    sel_hot   = sel_valid ? (lvec_t'(1) << sel_lvl) : '0;
    act_keep  = rfe ? (active & ~low_bit(active)) : active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      take_lvl <= '0;
      active   <= '0;
      pend     <= '0;
    end else begin
      take   <= sel_valid;
      if (sel_valid) take_lvl <= sel_lvl;
      active <= act_keep | sel_hot;
      pend   <= (pend & ~sel_hot) | set_vec;
    end
  end
endmodule

// File: rtl/evc_ret_store.sv
module evc_ret_store
  import evc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  lvl_t          wlvl,
  input  logic [AW-1:0] wdata,
  input  lvl_t          rlvl,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] mem [NLVL];

  always_ff @(posedge clk) begin
    if (we) mem[wlvl] <= wdata;
    rdata <= mem[rlvl];
  end
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int SRC_W   = 3,
  parameter int GP_BASE = 7,
  parameter int AW      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  emu_req,
  input  logic                  rst_evt_req,
  input  logic                  nmi_pin,
  input  logic                  wdog_expire,
  input  logic                  exc_req,
  input  logic                  swi_req,
  input  logic [3:0]            swi_lvl,
  input  logic [(1<<SRC_W)-1:0] irq,
  input  logic                  cfg_we,
  input  logic [SRC_W-1:0]      cfg_src,
  input  logic                  cfg_en,
  input  logic [3:0]            cfg_lvl,
  input  logic [AW-1:0]         pc_in,
  input  logic                  rfe,
  input  logic [3:0]            ret_sel,
  output logic                  take,
  output logic [3:0]            take_lvl,
  output logic [15:0]           active,
  output logic [AW-1:0]         ret_addr
);
  localparam lvl_t GPB = lvl_t'(GP_BASE);

  lvec_t gp_req_w;
  lvec_t set_vec;
  lvec_t pend_w;
  logic  sel_valid;
  lvl_t  sel_lvl;

  evc_sys_stage #(.SRC_W(SRC_W), .GP_BASE(GP_BASE)) u_sys (
    .clk(clk), .rst(rst), .irq(irq), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .gp_req(gp_req_w)
  );

  always_comb begin
    set_vec         = gp_req_w;
    set_vec[LV_EMU] = set_vec[LV_EMU] | emu_req;
    set_vec[LV_RST] = set_vec[LV_RST] | rst_evt_req;
    set_vec[LV_NMI] = set_vec[LV_NMI] | nmi_pin | wdog_expire;
    set_vec[LV_EXC] = set_vec[LV_EXC] | exc_req;
    if (swi_req && (swi_lvl >= GPB)) set_vec[swi_lvl] = 1'b1;
  end

  evc_core_prio u_core (
    .clk(clk), .rst(rst), .set_vec(set_vec), .rfe(rfe),
    .sel_valid(sel_valid), .sel_lvl(sel_lvl),
    .take(take), .take_lvl(take_lvl), .active(active), .pend(pend_w)
  );

  evc_ret_store #(.AW(AW)) u_ret (
    .clk(clk), .we(sel_valid), .wlvl(sel_lvl), .wdata(pc_in),
    .rlvl(ret_sel), .rdata(ret_addr)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk
  import evc_pkg::*;
#(
  parameter int GP_BASE = 7
) (
  input logic  clk,
  input logic  rst,
  input logic  take,
  input lvl_t  take_lvl,
  input logic  rfe,
  input lvec_t active,
  input lvec_t pend,
  input lvec_t gp_req
);
  localparam lvl_t GPB = lvl_t'(GP_BASE);

  function automatic lvec_t le_mask(lvl_t l);
    return (lvec_t'(2) << l) - lvec_t'(1);
  endfunction

  function automatic lvec_t hot(lvl_t l);
    return lvec_t'(1) << l;
  endfunction

  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  // R4: a take is strictly more urgent than all routines active before it
  a_r4_strict_over_active: assert property (@(posedge clk) disable iff (rst)
    (started && take) |-> (($past(active) & le_mask(take_lvl)) == '0));

  // R3: the level taken was the lowest pending one
  a_r3_lowest_pending: assert property (@(posedge clk) disable iff (rst)
    (started && take) |-> (($past(pend) & le_mask(take_lvl)) == hot(take_lvl)));

  // R4: a pending bit is dropped only by its own take
  a_r4_pending_held: assert property (@(posedge clk) disable iff (rst)
    started |-> ((($past(pend) & ~pend) & ~(take ? hot(take_lvl) : '0)) == '0));

  // R5: a return with no simultaneous take retires exactly one routine
  a_r5_rfe_drops_one: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rfe) && !take && ($past(active) != '0)) |->
      ($countones(active) == $countones($past(active)) - 1));

  // R2: the level reported on a take is marked active
  a_r2_take_active: assert property (@(posedge clk) disable iff (rst)
    take |-> active[take_lvl]);

  // R8: the system stage never drives a fixed core level
  a_r8_gp_only: assert property (@(posedge clk) disable iff (rst)
    (gp_req & ~le_mask(GPB) & ~hot(GPB) & le_mask(GPB)) == '0 &&
    (gp_req & (hot(GPB) - lvec_t'(1))) == '0);
endmodule

bind evc_top evc_chk #(.GP_BASE(GP_BASE)) u_chk (
  .clk(clk), .rst(rst), .take(take), .take_lvl(take_lvl), .rfe(rfe),
  .active(active), .pend(pend_w), .gp_req(gp_req_w)
);

// File: tb/test_evc_top.sv
module test_evc_top;
  localparam int SRC_W   = 3;
  localparam int NSRC    = 1 << SRC_W;
  localparam int GP_BASE = 7;
  localparam int AW      = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, emu_req, rst_evt_req, nmi_pin, wdog_expire, exc_req, swi_req;
  logic [3:0] swi_lvl, cfg_lvl, ret_sel, take_lvl;
  logic [NSRC-1:0] irq;
  logic cfg_we, cfg_en, rfe, take;
  logic [SRC_W-1:0] cfg_src;
  logic [AW-1:0] pc_in, ret_addr;
  logic [15:0] active;

  evc_top #(.SRC_W(SRC_W), .GP_BASE(GP_BASE), .AW(AW)) i_evc_top (
    .clk(clk), .rst(rst), .emu_req(emu_req), .rst_evt_req(rst_evt_req),
    .nmi_pin(nmi_pin), .wdog_expire(wdog_expire), .exc_req(exc_req),
    .swi_req(swi_req), .swi_lvl(swi_lvl), .irq(irq), .cfg_we(cfg_we),
    .cfg_src(cfg_src), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .pc_in(pc_in),
    .rfe(rfe), .ret_sel(ret_sel), .take(take), .take_lvl(take_lvl),
    .active(active), .ret_addr(ret_addr)
  );

  int n_vec = 0, n_bad = 0, tcnt = 0;
  bit done = 1'b0;

  logic [15:0] m_pend, m_act, m_gpq;
  logic        m_en  [NSRC];
  logic [3:0]  m_lvl [NSRC];
  logic [AW-1:0] m_ret [16];
  logic        m_wr  [16];
  int          last_lvl;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_of(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 16;
  endfunction

  task automatic clear_in();
    emu_req = 0; rst_evt_req = 0; nmi_pin = 0; wdog_expire = 0; exc_req = 0;
    swi_req = 0; swi_lvl = 0; irq = '0; cfg_we = 0; cfg_en = 0; cfg_lvl = 0;
    cfg_src = '0; rfe = 0;
  endtask

  // one clock: update the reference model from the requirements, then compare
  task automatic step();
    logic [15:0] setv, rt;
    int c, a;
    logic el;
    @(posedge clk);
    c  = first_of(m_pend);
    a  = first_of(m_act);
    el = (c < 16) && (c < a);
    setv = m_gpq;
    if (emu_req) setv[0] = 1'b1;
    if (rst_evt_req) setv[1] = 1'b1;
    if (nmi_pin || wdog_expire) setv[2] = 1'b1;
    if (exc_req) setv[3] = 1'b1;
    if (swi_req && swi_lvl >= GP_BASE) setv[swi_lvl] = 1'b1;
    rt = '0;
    for (int s = 0; s < NSRC; s++)
      if (m_en[s] && irq[s] && m_lvl[s] >= GP_BASE) rt[m_lvl[s]] = 1'b1;
    if (rfe && a < 16) m_act[a] = 1'b0;
    if (el) begin
      m_act[c] = 1'b1; m_pend[c] = 1'b0; m_ret[c] = pc_in; m_wr[c] = 1'b1;
      tcnt++; last_lvl = c;
    end
    m_pend = m_pend | setv;
    m_gpq  = rt;
    if (cfg_we) begin m_en[cfg_src] = cfg_en; m_lvl[cfg_src] = cfg_lvl; end
    #1;
    chk("R3 take strobe", {31'd0, take}, {31'd0, el});
    if (el) chk("R2 take level", {28'd0, take_lvl}, c);
    chk("R4 R5 active mask", {16'd0, active}, {16'd0, m_act});
    clear_in();
    pc_in = $urandom;
  endtask

  initial begin
    int unsigned sd;
    int t0;
    sd = $urandom(32'd4242);
    clear_in(); pc_in = '0; ret_sel = '0;
    m_pend = '0; m_act = '0; m_gpq = '0; last_lvl = 0;
    for (int s = 0; s < NSRC; s++) begin m_en[s] = 0; m_lvl[s] = 4'd15; end
    for (int l = 0; l < 16; l++) begin m_wr[l] = 0; m_ret[l] = '0; end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 take after reset", {31'd0, take}, 0);
    chk("R1 active after reset", {16'd0, active}, 0);

    // R7 / R6: watchdog path, latency two edges
    wdog_expire = 1; step();
    chk("R6 no take after one edge", {31'd0, take}, 0);
    step();
    chk("R7 watchdog raises NMI", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd2});
    rfe = 1; step();
    nmi_pin = 1; step(); step();
    chk("R7 pin raises NMI", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd2});
    rfe = 1; step(); step();

    // R3 / R4 / R5: exception beats software level 9, then nesting
    swi_req = 1; swi_lvl = 4'd9; exc_req = 1; step(); step();
    chk("R3 lowest level first", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd3});
    step(); step(); step();
    chk("R4 level 9 waits", {16'd0, active}, 32'h0008);
    rfe = 1; step(); step();
    chk("R5 waiting level taken after return", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd9});
    emu_req = 1; step(); step();
    chk("R4 nested emulation", {16'd0, active}, 32'h0201);
    rfe = 1; step();
    chk("R5 return clears most urgent", {16'd0, active}, 32'h0200);
    rfe = 1; step(); step();

    // R8 / R6: peripheral routing
    cfg_we = 1; cfg_src = 3'd2; cfg_en = 1; cfg_lvl = 4'd8; step();
    irq[2] = 1; step(); step();
    chk("R6 peripheral not yet taken", {31'd0, take}, 0);
    step();
    chk("R8 routed source taken", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd8});
    rfe = 1; step(); step();
    cfg_we = 1; cfg_src = 3'd3; cfg_en = 0; cfg_lvl = 4'd10; step();
    t0 = tcnt;
    irq[3] = 1; step(); step(); step(); step();
    chk("R8 disabled source ignored", tcnt, t0);
    cfg_we = 1; cfg_src = 3'd4; cfg_en = 1; cfg_lvl = 4'd2; step();
    irq[4] = 1; step(); step(); step(); step();
    chk("R8 core level assignment ignored", tcnt, t0);
    chk("R8 active untouched", {16'd0, active}, 0);

    // R9: software raise
    swi_req = 1; swi_lvl = 4'd5; step(); step(); step(); step();
    chk("R9 low software level ignored", tcnt, t0);
    swi_req = 1; swi_lvl = 4'd15; step(); step();
    chk("R9 software level 15 taken", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd15});
    rfe = 1; step();
    rst_evt_req = 1; step(); step();
    chk("R2 core reset event level", {27'd0, take, take_lvl}, {27'd0, 1'b1, 4'd1});
    rfe = 1; step();

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25) begin swi_req = 1; swi_lvl = 4'($urandom_range(0, 15)); end
      if ($urandom_range(0, 99) < 30) rfe = 1;
      if ($urandom_range(0, 99) < 5) exc_req = 1;
      if ($urandom_range(0, 99) < 2) emu_req = 1;
      if ($urandom_range(0, 99) < 3) nmi_pin = 1;
      if ($urandom_range(0, 99) < 15) irq = NSRC'($urandom);
      if ($urandom_range(0, 99) < 6) begin
        cfg_we = 1; cfg_src = SRC_W'($urandom); cfg_en = 1'($urandom);
        cfg_lvl = 4'($urandom_range(0, 15));
      end
      step();
    end

    // drain, then read back return registers (R10)
    for (int n = 0; n < 200 && (m_pend != 0 || m_act != 0 || m_gpq != 0); n++) begin
      rfe = 1; step();
    end
    for (int l = 0; l < 16; l++) begin
      if (m_wr[l]) begin
        logic [AW-1:0] e;
        e = m_ret[l];
        ret_sel = 4'(l); step();
        chk("R10 return register", ret_addr, e);
      end
    end
    chk("R10 last level returned", {28'd0, take_lvl}, last_lvl);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule